// File: doc/BRIEF.md
# Management Data Serial Bus Master

This block is a master for the two-wire PHY management bus. It drives the serial clock, sends clause-22 read and write frames, and turns the bidirectional data line around for reads. Software works through three word registers on a plain write/read port. The control word enables the master, sets the clock divider and shows an idle flag. The access word starts a frame and returns its result. The link word mirrors a vector of per-PHY link bits.

To run a transfer, software writes the access word with the go flag set, together with the PHY address, the register address, the direction and, for a write, the data. Go stays set while the frame is on the wire, and the hardware clears it when the frame ends. After a read, the access word holds the 16 bits that were shifted in. It also holds an acknowledge flag that shows whether the PHY pulled the line low in the second turnaround slot.

The register port has no back-pressure and no data stream, so it uses no valid/ready handshake. A write strobe takes effect at the clock edge where it is high. Read data is a combinational function of the read address and the current register state.

Top module: `mdio_master`

## Requirements
- R1: After reset, the control word (address 0) reads 0x8000_0000, meaning idle=1 (bit 31), enable=0 (bit 30) and divider=0 (bits 7:0). The access word (address 1) and the link word (address 2) both read 0, and the management clock is low.
- R2: While enable is set, the management clock has a period of exactly 2*(divider+1) system clocks. While enable is clear, the clock is held low.
- R3: A frame has 64 slots, in this order: 32 ones, start bits 0 then 1, opcode 1,0 for a read or 0,1 for a write, the PHY address, the register address, the turnaround 1,0, and then 16 data bits. All fields are sent MSB first. The master changes the line on falling clock edges, so each slot holds its value across the rising edge.
- R4: On a read, the master stops driving the line (output enable low) from turnaround slot 46 through data slot 63. The master drives the line only while a frame is in progress.
- R5: In the access word, go (bit 31) stays set from the write that starts a frame until the frame ends, and then clears by itself. The frame ends between 63 and 66 clock periods after the start write. The control word's idle bit always reads as the inverse of go.
- R6: The access word has these fields: go in bit 31, write in bit 30 (0 selects a read), acknowledge in bit 29, bits 28:26 reading 0, the register address in bits 25:21, the PHY address in bits 20:16 and the data in bits 15:0. When a read ends, the data field holds the 16 bits sampled on rising edges in slots 48 to 63.
- R7: When a read ends, the acknowledge bit is 1 only if the line was low at the rising edge of slot 47. Starting a new frame clears acknowledge, and a write frame leaves it at 0.
- R8: A write to the access word while go is set has no effect. A write with go clear updates the direction, address and data fields but starts no frame.
- R9: The link word shows the 32-bit link input vector, one bit per PHY address, captured one system clock after the vector is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address (0 control, 1 access, 2 link) |
| reg_wdata | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| link_in | input | 32 | Link status, one bit per PHY address |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Line value driven by the master |
| mdio_oe | output | 1 | Output enable for the data line |
| mdio_in | input | 1 | Line value seen at the pad |

## Verification
Register writes take effect at the edge after the strobe. The bench therefore reads back one system clock later, sampling read data one time unit after the falling edge. The link word is checked one edge after the input vector changes. Frame bits are recorded by a PHY model at each rising edge of the management clock, where R3 promises that the value is stable. The end of a frame is due between 63 and 66 clock periods after the start write, so the bench polls go on every system clock and checks the count it measures against that window for each divider it sweeps.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_ACC  = 2'd1;
  localparam logic [1:0] ADDR_LINK = 2'd2;

  localparam int ACC_GO  = 31;
  localparam int ACC_WR  = 30;
  localparam int ACC_ACK = 29;
  localparam int CTL_IDLE = 31;
  localparam int CTL_EN   = 30;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int NPHY   = 1 << ADDR_W;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic tick;

  assign tick      = en && (cnt >= div);
  assign rise_tick = tick && !mdc;
  assign fall_tick = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2
  mdc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(mdc));
  // R2
  mdc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              wr,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mdio_in,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic              done,
  output logic              ack,
  output logic [DATA_W-1:0] rdata
);
  localparam int FRAME_LEN = PRE_LEN + 4 + 2*ADDR_W + 2 + DATA_W;
  localparam int SLOT_W    = $clog2(FRAME_LEN);
  localparam int TA1       = PRE_LEN + 4 + 2*ADDR_W;
  localparam int TA2       = TA1 + 1;
  localparam int D0        = TA1 + 2;
  localparam int LAST      = FRAME_LEN - 1;

  logic              armed, run;
  logic [SLOT_W-1:0] cur;
  logic [FRAME_LEN-1:0] frame;

  assign frame = {{PRE_LEN{1'b1}}, 2'b01, (wr ? 2'b01 : 2'b10), phy, regad,
                  2'b10, (wr ? wdata : {DATA_W{1'b1}})};

  assign mdio_oe  = run && (wr || (int'(cur) < TA1));
  assign mdio_out = run ? frame[LAST - int'(cur)] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      run   <= 1'b0;
      cur   <= '0;
      done  <= 1'b0;
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        armed <= 1'b1;
        ack   <= 1'b0;
      end else if (fall_tick) begin
        if (armed) begin
          armed <= 1'b0;
          run   <= 1'b1;
          cur   <= '0;
        end else if (run) begin
          if (cur == SLOT_W'(LAST)) begin
            run  <= 1'b0;
            done <= 1'b1;
          end else begin
            cur <= cur + 1'b1;
          end
        end
      end
      if (rise_tick && run && !wr) begin
        if (cur == SLOT_W'(TA2)) ack <= !mdio_in;
        if (int'(cur) >= D0)     rdata <= {rdata[DATA_W-2:0], mdio_in};
      end
    end
  end

  // R3
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fall_tick) |=> $stable(cur));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic [31:0] link_in,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  logic              en;
  logic [DIV_W-1:0]  div;
  logic              go, wr_f, ack_f;
  logic [ADDR_W-1:0] phy_f, reg_f;
  logic [DATA_W-1:0] data_f;
  logic [NPHY-1:0]   link_q;
  logic              rise_tick, fall_tick, start;
  logic              seq_done, seq_ack;
  logic [DATA_W-1:0] seq_rdata;

  assign start = reg_wr && (reg_addr == ADDR_ACC) && !go && reg_wdata[ACC_GO];

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(en), .div(div),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rise_tick(rise_tick), .fall_tick(fall_tick),
    .wr(wr_f), .phy(phy_f), .regad(reg_f), .wdata(data_f),
    .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .done(seq_done), .ack(seq_ack), .rdata(seq_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      div    <= '0;
      go     <= 1'b0;
      wr_f   <= 1'b0;
      ack_f  <= 1'b0;
      phy_f  <= '0;
      reg_f  <= '0;
      data_f <= '0;
      link_q <= '0;
    end else begin
      link_q <= link_in;
      if (reg_wr && reg_addr == ADDR_CTRL) begin
        en  <= reg_wdata[CTL_EN];
        div <= reg_wdata[DIV_W-1:0];
      end
      if (reg_wr && reg_addr == ADDR_ACC && !go) begin
        wr_f   <= reg_wdata[ACC_WR];
        reg_f  <= reg_wdata[25:21];
        phy_f  <= reg_wdata[20:16];
        data_f <= reg_wdata[15:0];
        if (reg_wdata[ACC_GO]) begin
          go    <= 1'b1;
          ack_f <= 1'b0;
        end
      end
      if (seq_done) begin
        go <= 1'b0;
        if (!wr_f) begin
          data_f <= seq_rdata;
          ack_f  <= seq_ack;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_CTRL: begin
        rd_data[CTL_IDLE]    = !go;
        rd_data[CTL_EN]      = en;
        rd_data[DIV_W-1:0]   = div;
      end
      ADDR_ACC:  rd_data = {go, wr_f, ack_f, 3'b000, reg_f, phy_f, data_f};
      ADDR_LINK: rd_data = link_q;
      default:   rd_data = '0;
    endcase
  end

  // R5
  go_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go) |-> $past(seq_done));
  // R8
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !seq_done) |=> ($stable(wr_f) && $stable(phy_f) && $stable(reg_f)));
  // R7
  ack_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && wr_f) |-> !ack_f);
  // R4
  oe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> go);
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data;
  logic [31:0] link_in = '0;
  logic        mdc, mdio_out, mdio_oe, mdio_in;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // PHY model state
  int          k = 0;
  logic [63:0] seen;
  logic [63:0] oe_seen;
  bit          respond = 1'b0;
  logic [15:0] phy_data = '0;
  logic        phy_drive = 1'b1;

  always #5 clk = ~clk;

  assign mdio_in = mdio_oe ? mdio_out : phy_drive;

  mdio_master uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .link_in(link_in), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .mdio_in(mdio_in)
  );

  always @(posedge mdc) begin
    if ((k > 0 && k < 64) || (k == 0 && mdio_oe)) begin
      seen[63-k]    = mdio_in;
      oe_seen[63-k] = mdio_oe;
      k = k + 1;
    end
  end

  always @(negedge mdc) begin
    if (respond && k == 47)                 phy_drive = 1'b0;
    else if (respond && k >= 48 && k <= 63) phy_drive = phy_data[63-k];
    else                                    phy_drive = 1'b1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_all();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  function automatic logic [31:0] acc_word(bit go, bit wr, logic [4:0] ra,
                                           logic [4:0] pa, logic [15:0] dat);
    return {go, wr, 1'b0, 3'b000, ra, pa, dat};
  endfunction

  // Run one frame and check the bits on the wire, the timing and the result.
  task automatic do_frame(input int dv, input bit wr, input bit resp,
                          input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] dat);
    logic [31:0] r;
    logic [63:0] expf;
    int cyc;
    k = 0; respond = resp && !wr; phy_data = dat;
    seen = '0; oe_seen = '0;
    expf = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), pa, ra, 2'b10,
            (wr ? dat : 16'hFFFF)};
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = acc_word(1'b1, wr, ra, pa, dat);
    @(negedge clk);
    reg_wr = 1'b0;
    cyc = 1;
    rd_reg(2'd0, r);
    check("R5 idle low while busy", {63'd0, r[31]}, 64'd0);
    // R8: attempt to disturb the frame while go is set
    wr_reg(2'd1, acc_word(1'b1, !wr, ~ra, ~pa, ~dat));
    cyc += 2;
    rd_reg(2'd1, r);
    while (r[31] && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      rd_reg(2'd1, r);
    end
    check("R5 frame end window",
          {63'd0, (cyc >= 63*2*(dv+1)) && (cyc <= 66*2*(dv+1) + 4)}, 64'd1);
    if (wr) begin
      check("R3 write frame bits", seen, expf);
      check("R4 write drives all slots", oe_seen, 64'hFFFF_FFFF_FFFF_FFFF);
      check("R8 R7 write result word", {32'd0, r}, {32'd0, acc_word(1'b0, 1'b1, ra, pa, dat)});
    end else begin
      check("R3 read header bits", {18'd0, seen[63:18]}, {18'd0, expf[63:18]});
      check("R4 read released", {46'd0, oe_seen[17:0]}, 64'd0);
      check("R4 read header driven", {18'd0, oe_seen[63:18]}, {18'd0, {46{1'b1}}});
      check("R6 R7 read result word", {32'd0, r},
            {32'd0, resp ? {3'b001, 3'b000, ra, pa, dat}
                         : {3'b000, 3'b000, ra, pa, 16'hFFFF}});
    end
    rd_reg(2'd0, r);
    check("R5 idle after frame", {63'd0, r[31]}, 64'd1);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_all();
  end

  initial begin
    logic [31:0] r;
    time t0, t1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd_reg(2'd0, r); check("R1 control reset", {32'd0, r}, 64'h8000_0000);
    rd_reg(2'd1, r); check("R1 access reset", {32'd0, r}, 64'd0);
    rd_reg(2'd2, r); check("R1 link reset", {32'd0, r}, 64'd0);
    check("R1 R2 mdc low", {63'd0, mdc}, 64'd0);

    // R9: link capture one clock later
    for (int i = 0; i < 4; i++) begin
      logic [31:0] v;
      v = 32'h1 << (i * 9) | (32'hA5A5_0000 >> i);
      @(negedge clk); link_in = v;
      rd_reg(2'd2, r);
      check("R9 link not yet captured", {63'd0, r == v}, {63'd0, i == 0 && v == 0});
      @(negedge clk);
      rd_reg(2'd2, r);
      check("R9 link captured", {32'd0, r}, {32'd0, v});
    end

    // R8: go clear write updates fields, starts nothing
    wr_reg(2'd1, acc_word(1'b0, 1'b1, 5'd3, 5'd7, 16'h1234));
    rd_reg(2'd1, r);
    check("R8 fields without go", {32'd0, r}, {32'd0, acc_word(1'b0, 1'b1, 5'd3, 5'd7, 16'h1234)});
    repeat (20) @(negedge clk);
    check("R8 no frame without go", {63'd0, mdio_oe}, 64'd0);

    for (int dv = 0; dv < 4; dv++) begin
      wr_reg(2'd0, 32'h4000_0000 | dv);
      rd_reg(2'd0, r);
      check("R1 R2 control readback", {32'd0, r}, {32'd0, 32'hC000_0000 | dv});
      @(posedge mdc); t0 = $time;
      @(posedge mdc); t1 = $time;
      check("R2 mdc period", 64'((t1 - t0) / 10), 64'(2 * (dv + 1)));
      do_frame(dv, 1'b1, 1'b0, 5'(dv * 7 + 1), 5'(31 - dv), 16'hC3A5 ^ 16'(dv * 16'h1111));
      do_frame(dv, 1'b0, 1'b1, 5'(dv * 5 + 2), 5'(dv * 3 + 16), 16'h5A0F + 16'(dv * 16'h0123));
      do_frame(dv, 1'b0, 1'b0, 5'(31 - dv), 5'(dv), 16'h0000);
    end

    // R2: disabled master holds the clock low
    wr_reg(2'd0, 32'h0000_0002);
    repeat (10) @(negedge clk);
    check("R2 mdc held low when disabled", {63'd0, mdc}, 64'd0);
    finish_all();
  end
endmodule